// File: doc/BRIEF.md
# Variable-Page Translation Lookup

This block is a fully associative address translation buffer for a 32-bit processor. Each entry has its own page size, from 1 KB up to 16 MB in powers of four. An entry may be private to one process or shared by all processes. It can also be placed in one of sixteen protection zones. A zone protection word, supplied from outside, can widen the entry's own write and execute rights. It can also hide the entry from user-mode accesses.

A request presents a virtual address, an access kind (read, write or fetch) and a user/supervisor flag. All entries are compared in parallel against the current process ID and the zone word. A priority encoder then picks the lowest-indexed entry that qualifies. One cycle after the request, the block returns a registered result with a one-cycle valid pulse. The result is a miss, a protection fault or a hit. A hit also carries the physical address, the page-size code and the entry index.

Entries are loaded through a simple write port that selects the tag word, the data word or the owner ID of one entry. A lookup issued in the same cycle as a write still sees the old contents.

Top module: `vtlb_lookup`

## Requirements
- R1: Every cycle with `req_valid` high is followed, on the next cycle, by exactly one cycle of `rsp_valid` high. `rsp_valid` is low in every other cycle. After reset, `rsp_valid` is 0 and `rsp_result` is 2'b00.
- R2: Tag word layout: bit 6 is the valid flag, bits [9:7] are the size code, and bits [31:10] are the virtual page number. Size codes 0..7 mean 1 KB, 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB and 16 MB. A valid entry matches on address when the virtual address and the tag agree in all bits at and above the page size. Tag bits below the page size are ignored.
- R3: An entry whose 8-bit owner ID is zero matches under any process ID. An entry with a nonzero owner ID matches only when that ID equals `cur_pid`.
- R4: Data word layout: bits [7:4] are the zone number z, bit 8 is the write right and bit 9 is the execute right. The zone code is `zone_prot[31-2z:30-2z]`, and it acts as follows:
  - code 0 makes the entry invisible to user accesses, and the search continues past it;
  - code 1 keeps the entry's own rights;
  - code 2 grants write and execute to supervisor accesses only;
  - code 3 grants write and execute to every access.
- R5: When z is at least ZONE_CNT (default 12), or when ZONES_ON is 0, the zone code is taken as 1.
- R6: Access kinds are encoded as 0 read, 1 write and 2 fetch; kind 3 acts as a read. Reads are always permitted. A write without write right, or a fetch without execute right, on the selected entry gives result 2'b01. The search does not go on to later entries.
- R7: Among the entries that pass the address, owner and zone-visibility checks, the lowest index is selected. If none passes, the result is 2'b00. The code 2'b11 never appears.
- R8: On a hit, `rsp_result` is 2'b10 and `rsp_idx` is the selected entry. `rsp_size` is its size code. `rsp_paddr` takes data word bits at and above the page size, and the virtual address bits below it.
- R9: For a miss or a protection fault, `rsp_paddr`, `rsp_size` and `rsp_idx` are all zero.
- R10: When `wr_en` is high, `wr_sel` 0 writes the tag word, 1 writes the data word, and 2 writes the owner ID from `wr_data[7:0]` of entry `wr_idx`. A lookup in the same cycle uses the contents from before the write. Reset invalidates every entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | 2 | Word select: 0 tag, 1 data, 2 owner ID |
| wr_idx | input | 6 | Entry written |
| wr_data | input | 32 | Write value |
| cur_pid | input | 8 | Current process ID |
| zone_prot | input | 32 | Sixteen 2-bit zone codes |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_result | output | 2 | 00 miss, 01 protection fault, 10 hit |
| rsp_paddr | output | 32 | Physical address on a hit |
| rsp_size | output | 3 | Size code of the hit entry |
| rsp_idx | output | 6 | Index of the hit entry |

## Verification
The hardest case to reach from the ports is a user access to a higher-indexed entry at the same address, after a lower-indexed entry has been skipped because its zone code is 0. A second case is a zone number just past the configured zone count, where the forced code has to override a zone word of all zeros. The stimulus builds both on purpose: it loads two overlapping entries in different zones and steps the zone word through all four codes for both privilege levels. It also places one entry at zone 11 and another at zone 12. A random phase follows. Its addresses are taken from the stored tags, so that hits, faults and overlaps are common, and it mixes in same-cycle writes.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
  localparam int VA_W      = 32;
  localparam int TAG_V_BIT = 6;
  localparam int SZ_LO     = 7;
  localparam int ZS_LO     = 4;
  localparam int D_WR_BIT  = 8;
  localparam int D_EX_BIT  = 9;

  typedef enum logic [1:0] {
    RES_MISS = 2'b00,
    RES_PROT = 2'b01,
    RES_HIT  = 2'b10
  } res_e;

  typedef enum logic [1:0] {
    SEL_TAG  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_TID  = 2'd2
  } wsel_e;

  // offset mask (page size - 1) for a 3-bit size code; sizes step by 4x from 1 KB
  function automatic logic [VA_W-1:0] off_mask(input logic [2:0] code);
    logic [VA_W-1:0] one;
    one = 1;
    return (one << (10 + 2 * int'(code))) - one;
  endfunction
endpackage

// File: rtl/vtlb_store.sv
module vtlb_store #(
  parameter int ENTRIES = 64,
  parameter int PID_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_sel,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [vtlb_pkg::VA_W-1:0]   wr_data,
  output logic [vtlb_pkg::VA_W-1:0]   tag_q  [ENTRIES],
  output logic [vtlb_pkg::VA_W-1:0]   data_q [ENTRIES],
  output logic [PID_W-1:0]            tid_q  [ENTRIES]
);
  import vtlb_pkg::*;

  logic unused_hi;
  assign unused_hi = ^wr_data[VA_W-1:PID_W];

  // tag words carry the valid flag, so only they are reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
    end else if (wr_en && wr_sel == SEL_TAG) begin
      tag_q[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_sel == SEL_DATA) data_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_sel == SEL_TID) tid_q[wr_idx] <= wr_data[PID_W-1:0];
  end
endmodule

// File: rtl/vtlb_match.sv
module vtlb_match #(
  parameter int ENTRIES  = 64,
  parameter int PID_W    = 8,
  parameter int ZONE_CNT = 12,
  parameter bit ZONES_ON = 1'b1
) (
  input  logic [vtlb_pkg::VA_W-1:0] tag_q  [ENTRIES],
  input  logic [vtlb_pkg::VA_W-1:0] data_q [ENTRIES],
  input  logic [PID_W-1:0]          tid_q  [ENTRIES],
  input  logic [vtlb_pkg::VA_W-1:0] vaddr,
  input  logic                      user,
  input  logic [PID_W-1:0]          cur_pid,
  input  logic [31:0]               zone_prot,
  output logic [ENTRIES-1:0]        qual,
  output logic [ENTRIES-1:0]        wr_ok,
  output logic [ENTRIES-1:0]        ex_ok
);
  import vtlb_pkg::*;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [VA_W-1:0] omask;
    logic [3:0]      zsel;
    logic [4:0]      zpos;
    logic [1:0]      zcode;
    logic            addr_hit, pid_hit, hidden;
    logic            unused_low;

    assign unused_low = ^data_q[g][ZS_LO-1:0];
    assign omask      = off_mask(tag_q[g][SZ_LO +: 3]);
    assign addr_hit   = ((vaddr ^ tag_q[g]) & ~omask) == '0;
    assign pid_hit    = (tid_q[g] == '0) || (tid_q[g] == cur_pid);
    assign zsel       = data_q[g][ZS_LO +: 4];
    assign zpos       = 5'(30 - 2 * int'(zsel));

    always_comb begin
      if (!ZONES_ON || int'(zsel) >= ZONE_CNT) zcode = 2'd1;
      else                                     zcode = zone_prot[zpos +: 2];
    end

    assign hidden   = (zcode == 2'd0) && user;
    assign qual[g]  = tag_q[g][TAG_V_BIT] && addr_hit && pid_hit && !hidden;
    assign wr_ok[g] = data_q[g][D_WR_BIT] || zcode == 2'd3 || (zcode == 2'd2 && !user);
    assign ex_ok[g] = data_q[g][D_EX_BIT] || zcode == 2'd3 || (zcode == 2'd2 && !user);
  end
endmodule

// File: rtl/vtlb_prio.sv
module vtlb_prio #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] qual,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // scan from the top so the lowest qualifying index is the last assignment
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (qual[i]) idx = IDX_W'(i);
    end
  end

  assign found = |qual;
endmodule

// File: rtl/vtlb_lookup.sv
module vtlb_lookup #(
  parameter int ENTRIES  = 64,
  parameter int PID_W    = 8,
  parameter int ZONE_CNT = 12,
  parameter bit ZONES_ON = 1'b1,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic [PID_W-1:0] cur_pid,
  input  logic [31:0]      zone_prot,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic [1:0]       rsp_result,
  output logic [31:0]      rsp_paddr,
  output logic [2:0]       rsp_size,
  output logic [IDX_W-1:0] rsp_idx
);
  import vtlb_pkg::*;

  logic [VA_W-1:0]    tag_q  [ENTRIES];
  logic [VA_W-1:0]    data_q [ENTRIES];
  logic [PID_W-1:0]   tid_q  [ENTRIES];
  logic [ENTRIES-1:0] qual, wr_ok, ex_ok;
  logic               found;
  logic [IDX_W-1:0]   win;

  vtlb_store #(.ENTRIES(ENTRIES), .PID_W(PID_W)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .tag_q(tag_q), .data_q(data_q), .tid_q(tid_q)
  );

  vtlb_match #(.ENTRIES(ENTRIES), .PID_W(PID_W), .ZONE_CNT(ZONE_CNT),
               .ZONES_ON(ZONES_ON)) match_i (
    .tag_q(tag_q), .data_q(data_q), .tid_q(tid_q), .vaddr(req_vaddr),
    .user(req_user), .cur_pid(cur_pid), .zone_prot(zone_prot),
    .qual(qual), .wr_ok(wr_ok), .ex_ok(ex_ok)
  );

  vtlb_prio #(.ENTRIES(ENTRIES)) prio_i (
    .qual(qual), .found(found), .idx(win)
  );

  // selected entry and result, combinational ahead of the output register
  logic [2:0]      sel_code;
  logic [VA_W-1:0] sel_mask, pa_next;
  logic            deny;
  res_e            res_next;

  assign sel_code = tag_q[win][SZ_LO +: 3];
  assign sel_mask = off_mask(sel_code);
  assign pa_next  = (data_q[win] & ~sel_mask) | (req_vaddr & sel_mask);
  assign deny     = (req_kind == 2'd1 && !wr_ok[win]) ||
                    (req_kind == 2'd2 && !ex_ok[win]);

  always_comb begin
    if (!found)    res_next = RES_MISS;
    else if (deny) res_next = RES_PROT;
    else           res_next = RES_HIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_result <= RES_MISS;
      rsp_paddr  <= '0;
      rsp_size   <= '0;
      rsp_idx    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_result <= res_next;
        if (res_next == RES_HIT) begin
          rsp_paddr <= pa_next;
          rsp_size  <= sel_code;
          rsp_idx   <= win;
        end else begin
          rsp_paddr <= '0;
          rsp_size  <= '0;
          rsp_idx   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/vtlb_lookup_chk.sv
module vtlb_lookup_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [31:0]      req_vaddr,
  input logic             rsp_valid,
  input logic [1:0]       rsp_result,
  input logic [31:0]      rsp_paddr,
  input logic [2:0]       rsp_size,
  input logic [IDX_W-1:0] rsp_idx
);
  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R1
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R7
  res_code_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_result != 2'b11);

  // R9
  nohit_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_result != 2'b10) |->
      (rsp_paddr == 32'd0 && rsp_size == 3'd0 && rsp_idx == '0));

  // R8
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid ##1 (rsp_valid && rsp_result == 2'b10)) |->
      ((rsp_paddr ^ $past(req_vaddr)) &
       ((32'd1 << (10 + 2 * int'(rsp_size))) - 32'd1)) == 32'd0);
endmodule

bind vtlb_lookup vtlb_lookup_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_paddr(rsp_paddr),
  .rsp_size(rsp_size), .rsp_idx(rsp_idx)
);

// File: tb/vtlb_lookup_tb_top.sv
module vtlb_lookup_tb_top;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [5:0]  wr_idx = 6'd0;
  logic [31:0] wr_data = 32'd0;
  logic [7:0]  cur_pid = 8'd0;
  logic [31:0] zone_prot = 32'h5555_5555;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = 32'd0;
  logic [1:0]  req_kind = 2'd0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_result;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_size;
  logic [5:0]  rsp_idx;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  vtlb_lookup dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .cur_pid(cur_pid), .zone_prot(zone_prot),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .req_user(req_user), .rsp_valid(rsp_valid), .rsp_result(rsp_result),
    .rsp_paddr(rsp_paddr), .rsp_size(rsp_size), .rsp_idx(rsp_idx)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_tag [N];
  logic [31:0] m_data[N];
  logic [7:0]  m_tid [N];

  logic        e_valid = 0;
  logic [1:0]  e_res = 0;
  logic [31:0] e_pa = 0;
  logic [2:0]  e_sz = 0;
  int          e_idx = 0;

  function automatic void ref_lookup(input logic [31:0] va, input logic [1:0] kind,
                                     input logic usr, input logic [7:0] pid,
                                     input logic [31:0] zp, output logic [1:0] res,
                                     output logic [31:0] pa, output logic [2:0] sz,
                                     output int idx);
    res = 2'b00; pa = 0; sz = 0; idx = 0;
    for (int i = 0; i < N; i++) begin
      longint unsigned psize;
      int code, z, zc;
      bit w, x;
      if (!m_tag[i][6]) continue;
      code  = int'(m_tag[i][9:7]);
      psize = longint'(1024) << (2 * code);
      if ((longint'(va) / psize) != (longint'(m_tag[i] & 32'hFFFF_FC00) / psize)) continue;
      if (m_tid[i] != 0 && m_tid[i] != pid) continue;
      z  = int'(m_data[i][7:4]);
      zc = int'((zp >> (30 - 2 * z)) & 32'd3);
      if (z >= 12) zc = 1;
      if (zc == 0 && usr) continue;
      w = m_data[i][8] || zc == 3 || (zc == 2 && !usr);
      x = m_data[i][9] || zc == 3 || (zc == 2 && !usr);
      if ((kind == 2'd1 && !w) || (kind == 2'd2 && !x)) begin
        res = 2'b01;
        return;
      end
      res = 2'b10; idx = i; sz = 3'(code);
      pa  = 32'((longint'(m_data[i]) / psize) * psize + (longint'(va) % psize));
      return;
    end
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_valid = 0;
      for (int i = 0; i < N; i++) m_tag[i] = 0;
    end else begin
      e_valid = req_valid;
      if (req_valid) ref_lookup(req_vaddr, req_kind, req_user, cur_pid, zone_prot,
                                e_res, e_pa, e_sz, e_idx);
      if (wr_en) begin
        if (wr_sel == 2'd0) m_tag[wr_idx] = wr_data;
        else if (wr_sel == 2'd1) m_data[wr_idx] = wr_data;
        else if (wr_sel == 2'd2) m_tid[wr_idx] = wr_data[7:0];
      end
    end
  end

  // every-clock comparison against the model (R1, plus the phase's requirement)
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (rsp_valid !== e_valid) begin
        n_bad++;
        $display("FAIL R1 rsp_valid act=%0b exp=%0b", rsp_valid, e_valid);
      end else if (e_valid && (rsp_result !== e_res || rsp_paddr !== e_pa ||
                               rsp_size !== e_sz || int'(rsp_idx) != e_idx)) begin
        n_bad++;
        $display("FAIL %s model act=%0d/%h/%0d/%0d exp=%0d/%h/%0d/%0d", cur_req,
                 rsp_result, rsp_paddr, rsp_size, rsp_idx, e_res, e_pa, e_sz, e_idx);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mk_tag(input logic [31:0] a, input logic [2:0] c);
    return (a & 32'hFFFF_FC00) | (32'(c) << 7) | 32'h40;
  endfunction

  function automatic logic [31:0] mk_data(input logic [31:0] rpn, input bit w,
                                          input bit x, input logic [3:0] z);
    return (rpn & 32'hFFFF_FC00) | (32'(x) << 9) | (32'(w) << 8) | (32'(z) << 4);
  endfunction

  function automatic logic [31:0] zp_z2(input logic [1:0] c);
    return (32'h5555_5555 & ~(32'h3 << 26)) | (32'(c) << 26);
  endfunction

  task automatic wr(input logic [1:0] s, input int i, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_idx = 6'(i); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic put(input int i, input logic [31:0] t, input logic [31:0] d,
                     input logic [7:0] tid);
    wr(2'd1, i, d);
    wr(2'd2, i, 32'(tid));
    wr(2'd0, i, t);
  endtask

  task automatic look(input string rq, input logic [31:0] va, input logic [1:0] k,
                      input bit u, input logic [1:0] xr, input logic [31:0] xpa,
                      input int xidx);
    cur_req = rq;
    req_valid = 1; req_vaddr = va; req_kind = k; req_user = u;
    @(negedge clk);
    req_valid = 0;
    n_chk++;
    if (rsp_result !== xr || rsp_paddr !== xpa || int'(rsp_idx) != xidx) begin
      n_bad++;
      $display("FAIL %s va=%h act=%0d/%h/%0d exp=%0d/%h/%0d", rq, va,
               rsp_result, rsp_paddr, rsp_idx, xr, xpa, xidx);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_result !== 2'b00) begin
      n_bad++;
      $display("FAIL R1 reset act=%0b/%0d exp=0/0", rsp_valid, rsp_result);
    end

    // R7 empty table misses; R10 reset invalidated all entries
    look("R10", 32'h0012_3400, 2'd0, 0, 2'b00, 0, 0);

    // R2/R8 1 KB page, R6 rights
    put(5, mk_tag(32'h0012_3400, 0), mk_data(32'h8000_0400, 1, 0, 1), 8'h00);
    look("R8", 32'h0012_37FF, 2'd0, 0, 2'b10, 32'h8000_07FF, 5);
    look("R6", 32'h0012_37FF, 2'd1, 0, 2'b10, 32'h8000_07FF, 5);
    look("R6", 32'h0012_3400, 2'd2, 0, 2'b01, 0, 0);
    look("R9", 32'h0012_3400, 2'd2, 1, 2'b01, 0, 0);
    look("R2", 32'h0012_3800, 2'd0, 0, 2'b00, 0, 0);

    // R2 16 MB page, and 16 KB page with stray tag/rpn bits below page size
    put(3, mk_tag(32'h0500_0000, 7), mk_data(32'h1F00_0000, 1, 1, 0), 8'h00);
    look("R2", 32'h05AB_CDEF, 2'd2, 0, 2'b10, 32'h1FAB_CDEF, 3);
    look("R2", 32'h0600_0000, 2'd0, 0, 2'b00, 0, 0);
    put(4, mk_tag(32'h0901_2C00, 2), mk_data(32'h2000_3C00, 1, 1, 1), 8'h00);
    look("R2", 32'h0901_0010, 2'd0, 0, 2'b10, 32'h2000_0010, 4);

    // R3 owner ID
    put(10, mk_tag(32'h7000_0000, 1), mk_data(32'h3000_0000, 1, 1, 1), 8'h22);
    cur_pid = 8'h22;
    look("R3", 32'h7000_0ABC, 2'd0, 1, 2'b10, 32'h3000_0ABC, 10);
    cur_pid = 8'h23;
    look("R3", 32'h7000_0ABC, 2'd0, 1, 2'b00, 0, 0);
    look("R3", 32'h05AB_CDEF, 2'd0, 1, 2'b10, 32'h1FAB_CDEF, 3);

    // R4 zones: entry 20 in zone 2 (no own rights), entry 30 behind it in zone 1
    put(20, mk_tag(32'h4000_0000, 1), mk_data(32'h5000_0000, 0, 0, 2), 8'h00);
    put(30, mk_tag(32'h4000_0000, 1), mk_data(32'h6000_0000, 1, 0, 1), 8'h00);
    zone_prot = zp_z2(2'd0);
    look("R4", 32'h4000_0100, 2'd0, 1, 2'b10, 32'h6000_0100, 30);
    look("R4", 32'h4000_0100, 2'd0, 0, 2'b10, 32'h5000_0100, 20);
    look("R4", 32'h4000_0100, 2'd1, 0, 2'b01, 0, 0);
    zone_prot = zp_z2(2'd1);
    look("R4", 32'h4000_0100, 2'd1, 1, 2'b01, 0, 0);
    zone_prot = zp_z2(2'd2);
    look("R4", 32'h4000_0100, 2'd1, 0, 2'b10, 32'h5000_0100, 20);
    look("R4", 32'h4000_0100, 2'd1, 1, 2'b01, 0, 0);
    look("R6", 32'h4000_0100, 2'd2, 1, 2'b01, 0, 0);
    zone_prot = zp_z2(2'd3);
    look("R4", 32'h4000_0100, 2'd2, 1, 2'b10, 32'h5000_0100, 20);

    // R5 zone past configured count forces code 1
    zone_prot = 32'h0;
    put(25, mk_tag(32'h4400_0000, 1), mk_data(32'h7000_0000, 0, 1, 12), 8'h00);
    put(26, mk_tag(32'h4500_0000, 1), mk_data(32'h7100_0000, 0, 1, 11), 8'h00);
    look("R5", 32'h4400_0004, 2'd2, 1, 2'b10, 32'h7000_0004, 25);
    look("R5", 32'h4500_0004, 2'd2, 1, 2'b00, 0, 0);
    look("R6", 32'h4400_0004, 2'd3, 1, 2'b10, 32'h7000_0004, 25);

    // R7 priority between overlapping entries
    zone_prot = 32'h5555_5555;
    put(50, mk_tag(32'h4800_0000, 0), mk_data(32'hB000_0000, 1, 1, 1), 8'h00);
    put(40, mk_tag(32'h4800_0000, 0), mk_data(32'hA000_0000, 1, 1, 1), 8'h00);
    look("R7", 32'h4800_0123, 2'd0, 0, 2'b10, 32'hA000_0123, 40);
    wr(2'd0, 40, 32'h0);
    look("R7", 32'h4800_0123, 2'd0, 0, 2'b10, 32'hB000_0123, 50);

    // R10 same-cycle write sees old contents
    wr_en = 1; wr_sel = 2'd0; wr_idx = 6'd50; wr_data = 32'h0;
    look("R10", 32'h4800_0123, 2'd0, 0, 2'b10, 32'hB000_0123, 50);
    wr_en = 0;
    look("R10", 32'h4800_0123, 2'd0, 0, 2'b00, 0, 0);

    // random phase, checked by the model every cycle
    cur_req = "R2/R3/R4/R6/R7/R8";
    for (int i = 0; i < N; i++) begin
      logic [31:0] t;
      t = $urandom;
      t[6] = ($urandom % 5) != 0;
      put(i, t, $urandom, ($urandom % 2) ? 8'h00 : 8'(8'h22 + ($urandom % 2)));
    end
    for (int n = 0; n < 2000; n++) begin
      int k;
      k = $urandom % N;
      req_valid = ($urandom % 4) != 0;
      req_vaddr = m_tag[k] ^ ($urandom & 32'h000F_FFFF);
      req_kind  = 2'($urandom);
      req_user  = 1'($urandom);
      cur_pid   = 8'(8'h22 + ($urandom % 2));
      zone_prot = $urandom;
      wr_en     = ($urandom % 6) == 0;
      wr_sel    = 2'($urandom % 3);
      wr_idx    = 6'($urandom);
      wr_data   = $urandom | 32'h40;
      @(negedge clk);
    end
    req_valid = 0; wr_en = 0;
    @(negedge clk);
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule